// File: doc/BRIEF.md
# Block-Based Pattern Sequencer

This block drives the read address of a vector pattern memory from a small program of sequence lines. Each line plays one block of contiguous vectors and carries its own controls: a replay count (or endless replay), an event condition that must hold before the block starts, an action on one of four cross-module signal lines, and a conditional branch to another line. A line can also call a run of lines as a subroutine. The engine returns to the line after the call once the line marked as the end of that run has finished. Only one call level exists. A call met while already inside a called run is skipped like an empty line.

Event conditions are Boolean functions of eight external event inputs, each stored as a truth table with one bit for every input pattern. Two fixed condition indices mean "always" and "never", so a branch can be unconditional or disabled. This lets a one-time setup block be followed by a loop that starts further down. A step mode lets an operator pulse an input that satisfies a pending start condition or branch.

The sequence memory, the block table (start address and last offset per block) and the condition tables are loaded through write ports while the engine is idle.

Top module: `blkseq_engine`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `vec_valid`, `running`, `done` and all `sig_out` bits are 0.
- R2: With the engine idle, sampling `run_en` high starts line 0. All `sig_out` bits read 0 one cycle later, and the first vector is output after the third rising edge, counted from the edge that sampled `run_en`.
- R3: A block with start S and last-offset F outputs S, S+1, … S+F with `vec_valid` high on consecutive cycles. A line's replay field holds count−1, so values 0…65535 play the block 1…65536 times back to back.
- R4: When a line's endless flag is 1, its block replays with no gap until `run_en` is sampled low.
- R5: Before a line's block starts, `vec_valid` stays low for as long as the line's start condition is false. Playback begins on the edge where the condition is sampled true.
- R6: A condition index of 0 is always true and index 1 is never true. Any index k ≥ 2 reads bit `ev_in` of programmable table k−2, which is written through `cnd_w_idx`/`cnd_w_pat`/`cnd_w_val`.
- R7: After a line's last vector, a true branch condition makes the branch target the next line. A false condition moves to the following line, so an always-true branch skips the lines in between.
- R8: When a line's first vector is output, `sig_out[ssel]` takes the line's signal value. The other signal bits are unchanged.
- R9: A call line (`seq_w_call`=1) continues at its target line. At the end of a line flagged as run end (`seq_w_ret`=1), the engine returns to the line after the call. Outside a called run, the end flag has no effect.
- R10: After the last memory line finishes without a taken branch, `done` is 1 while `running` and `vec_valid` are 0. This holds while `run_en` stays high.
- R11: In step mode (`step_mode`=1), a `step_go` pulse satisfies the pending start condition or branch condition on the edge where it is sampled.
- R12: Sampling `run_en` low returns the engine to idle on that edge: `running`, `done` and `vec_valid` read 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Start (level high from idle) and stop (low) |
| ev_in | input | EV_W | External event inputs |
| step_mode | input | 1 | Enables manual satisfy |
| step_go | input | 1 | Manual satisfy pulse |
| seq_we | input | 1 | Sequence line write strobe |
| seq_waddr | input | LINE_AW | Line written |
| seq_w_call | input | 1 | Line calls a run of lines instead of a block |
| seq_w_ret | input | 1 | Line ends a called run |
| seq_w_tgt | input | TGT_W | Block index, or first line of the called run |
| seq_w_rep | input | REP_W | Replay count minus one |
| seq_w_inf | input | 1 | Endless replay |
| seq_w_wcond | input | CW | Start condition index |
| seq_w_ssel | input | log2(NSIG) | Signal line acted on |
| seq_w_sval | input | 1 | Value given to that signal line |
| seq_w_jcond | input | CW | Branch condition index |
| seq_w_jline | input | LINE_AW | Branch target line |
| blk_we | input | 1 | Block table write strobe |
| blk_waddr | input | BLK_AW | Block written |
| blk_w_start | input | AW | Block start address |
| blk_w_last | input | AW | Block length minus one |
| cnd_we | input | 1 | Condition table write strobe |
| cnd_w_idx | input | CW | Condition index written (2 and up) |
| cnd_w_pat | input | EV_W | Event pattern addressed |
| cnd_w_val | input | 1 | Truth value for that pattern |
| vec_addr | output | AW | Vector memory address |
| vec_valid | output | 1 | Address is an output vector |
| sig_out | output | NSIG | Cross-module signal lines |
| running | output | 1 | Engine is executing lines |
| done | output | 1 | Program has ended |

## Verification
The first vector of a run is due after the third rising edge following the edge that samples `run_en`. Between the last vector of one block and the first of the next there are three empty cycles when the start condition already holds, and one more for each call line. A branch is decided on the second edge after the last vector appears, and a start condition on the edge it is sampled true. The bench drives and samples at falling edges. Each step-mode pulse is timed to cover exactly the deciding edge. Address streams are compared entry by entry against a table as vectors appear, and stall and stop checks fall on counted falling edges.

// File: rtl/blkseq_pkg.sv
package blkseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LOAD = 3'd1,
    ST_WAIT = 3'd2,
    ST_PLAY = 3'd3,
    ST_JUMP = 3'd4,
    ST_DONE = 3'd5
  } seq_state_e;

  // fixed condition indices
  localparam int unsigned COND_ALWAYS = 0;
  localparam int unsigned COND_NEVER  = 1;

endpackage

// File: rtl/blkseq_linemem.sv
module blkseq_linemem #(
  parameter int LINE_AW   = 4,
  parameter int TGT_W     = 4,
  parameter int REP_W     = 16,
  parameter int CW        = 2,
  parameter int SSEL_W    = 2
) (
  input  logic              clk,
  input  logic              we,
  input  logic [LINE_AW-1:0] waddr,
  input  logic              w_call,
  input  logic              w_ret,
  input  logic [TGT_W-1:0]  w_tgt,
  input  logic [REP_W-1:0]  w_rep,
  input  logic              w_inf,
  input  logic [CW-1:0]     w_wcond,
  input  logic [SSEL_W-1:0] w_ssel,
  input  logic              w_sval,
  input  logic [CW-1:0]     w_jcond,
  input  logic [LINE_AW-1:0] w_jline,
  input  logic [LINE_AW-1:0] raddr,
  output logic              r_call,
  output logic              r_ret,
  output logic [TGT_W-1:0]  r_tgt,
  output logic [REP_W-1:0]  r_rep,
  output logic              r_inf,
  output logic [CW-1:0]     r_wcond,
  output logic [SSEL_W-1:0] r_ssel,
  output logic              r_sval,
  output logic [CW-1:0]     r_jcond,
  output logic [LINE_AW-1:0] r_jline
);
  localparam int DEPTH = 2 ** LINE_AW;

  logic              call_m  [DEPTH];
  logic              ret_m   [DEPTH];
  logic [TGT_W-1:0]  tgt_m   [DEPTH];
  logic [REP_W-1:0]  rep_m   [DEPTH];
  logic              inf_m   [DEPTH];
  logic [CW-1:0]     wcond_m [DEPTH];
  logic [SSEL_W-1:0] ssel_m  [DEPTH];
  logic              sval_m  [DEPTH];
  logic [CW-1:0]     jcond_m [DEPTH];
  logic [LINE_AW-1:0] jline_m [DEPTH];

  // storage array: no reset, written only on strobe
  always_ff @(posedge clk) begin
    if (we) begin
      call_m[waddr]  <= w_call;
      ret_m[waddr]   <= w_ret;
      tgt_m[waddr]   <= w_tgt;
      rep_m[waddr]   <= w_rep;
      inf_m[waddr]   <= w_inf;
      wcond_m[waddr] <= w_wcond;
      ssel_m[waddr]  <= w_ssel;
      sval_m[waddr]  <= w_sval;
      jcond_m[waddr] <= w_jcond;
      jline_m[waddr] <= w_jline;
    end
  end

  always_comb begin
    r_call  = call_m[raddr];
    r_ret   = ret_m[raddr];
    r_tgt   = tgt_m[raddr];
    r_rep   = rep_m[raddr];
    r_inf   = inf_m[raddr];
    r_wcond = wcond_m[raddr];
    r_ssel  = ssel_m[raddr];
    r_sval  = sval_m[raddr];
    r_jcond = jcond_m[raddr];
    r_jline = jline_m[raddr];
  end

endmodule

// File: rtl/blkseq_blktab.sv
module blkseq_blktab #(
  parameter int BLK_AW = 3,
  parameter int AW     = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic [BLK_AW-1:0] waddr,
  input  logic [AW-1:0]     w_start,
  input  logic [AW-1:0]     w_last,
  input  logic [BLK_AW-1:0] raddr,
  output logic [AW-1:0]     r_start,
  output logic [AW-1:0]     r_last
);
  localparam int NBLK = 2 ** BLK_AW;

  logic [AW-1:0] start_m [NBLK];
  logic [AW-1:0] last_m  [NBLK];

  always_ff @(posedge clk) begin
    if (we) begin
      start_m[waddr] <= w_start;
      last_m[waddr]  <= w_last;
    end
  end

  assign r_start = start_m[raddr];
  assign r_last  = last_m[raddr];

endmodule

// File: rtl/blkseq_condtab.sv
module blkseq_condtab
  import blkseq_pkg::*;
#(
  parameter int EV_W = 8,
  parameter int CW   = 2
) (
  input  logic            clk,
  input  logic            we,
  input  logic [CW-1:0]   w_idx,
  input  logic [EV_W-1:0] w_pat,
  input  logic            w_val,
  input  logic [EV_W-1:0] ev,
  input  logic [CW-1:0]   idx_a,
  input  logic [CW-1:0]   idx_b,
  output logic            hit_a,
  output logic            hit_b
);
  localparam int NIDX  = 2 ** CW;
  localparam int NPAT  = 2 ** EV_W;

  logic [NIDX-1:0] hit_v;

  assign hit_v[COND_ALWAYS] = 1'b1;
  assign hit_v[COND_NEVER]  = 1'b0;

  for (genvar g = 2; g < NIDX; g++) begin : g_tbl
    logic [NPAT-1:0] row;
    always_ff @(posedge clk) begin
      if (we && (w_idx == CW'(g))) begin
        row[w_pat] <= w_val;
      end
    end
    assign hit_v[g] = row[ev];
  end

  assign hit_a = hit_v[idx_a];
  assign hit_b = hit_v[idx_b];

endmodule

// File: rtl/blkseq_addrgen.sv
module blkseq_addrgen #(
  parameter int AW    = 12,
  parameter int REP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  input  logic [AW-1:0]    base_in,
  input  logic [AW-1:0]    span_in,
  input  logic [REP_W-1:0] rep_in,
  input  logic             inf_in,
  output logic [AW-1:0]    addr,
  output logic             last_vec
);
  logic [AW-1:0]    addr_q, addr_d;
  logic [AW-1:0]    off_q, off_d;
  logic [AW-1:0]    base_q, span_q;
  logic [REP_W-1:0] rep_q, rep_d;
  logic             inf_q;
  logic             wrap;

  assign wrap     = (off_q == span_q);
  assign last_vec = wrap && (rep_q == '0) && !inf_q;
  assign addr     = addr_q;

  always_comb begin
    addr_d = addr_q;
    off_d  = off_q;
    rep_d  = rep_q;
    if (load) begin
      addr_d = base_in;
      off_d  = '0;
      rep_d  = rep_in;
    end else if (adv && !last_vec) begin
      if (wrap) begin
        addr_d = base_q;
        off_d  = '0;
        if (!inf_q) rep_d = rep_q - 1'b1;
      end else begin
        addr_d = addr_q + 1'b1;
        off_d  = off_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      off_q  <= '0;
      rep_q  <= '0;
      base_q <= '0;
      span_q <= '0;
      inf_q  <= 1'b0;
    end else begin
      if (load || adv) begin
        addr_q <= addr_d;
        off_q  <= off_d;
        rep_q  <= rep_d;
      end
      if (load) begin
        base_q <= base_in;
        span_q <= span_in;
        inf_q  <= inf_in;
      end
    end
  end

endmodule

// File: rtl/blkseq_engine.sv
module blkseq_engine
  import blkseq_pkg::*;
#(
  parameter int EV_W    = 8,
  parameter int LINE_AW = 4,
  parameter int BLK_AW  = 3,
  parameter int CW      = 2,
  parameter int AW      = 12,
  parameter int REP_W   = 16,
  parameter int NSIG    = 4,
  localparam int SSEL_W = $clog2(NSIG),
  localparam int TGT_W  = (BLK_AW > LINE_AW) ? BLK_AW : LINE_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_en,
  input  logic [EV_W-1:0]    ev_in,
  input  logic               step_mode,
  input  logic               step_go,
  input  logic               seq_we,
  input  logic [LINE_AW-1:0] seq_waddr,
  input  logic               seq_w_call,
  input  logic               seq_w_ret,
  input  logic [TGT_W-1:0]   seq_w_tgt,
  input  logic [REP_W-1:0]   seq_w_rep,
  input  logic               seq_w_inf,
  input  logic [CW-1:0]      seq_w_wcond,
  input  logic [SSEL_W-1:0]  seq_w_ssel,
  input  logic               seq_w_sval,
  input  logic [CW-1:0]      seq_w_jcond,
  input  logic [LINE_AW-1:0] seq_w_jline,
  input  logic               blk_we,
  input  logic [BLK_AW-1:0]  blk_waddr,
  input  logic [AW-1:0]      blk_w_start,
  input  logic [AW-1:0]      blk_w_last,
  input  logic               cnd_we,
  input  logic [CW-1:0]      cnd_w_idx,
  input  logic [EV_W-1:0]    cnd_w_pat,
  input  logic               cnd_w_val,
  output logic [AW-1:0]      vec_addr,
  output logic               vec_valid,
  output logic [NSIG-1:0]    sig_out,
  output logic               running,
  output logic               done
);

  seq_state_e st_q, st_d;
  logic [LINE_AW-1:0] pc_q, pc_d;
  logic [LINE_AW-1:0] rtn_q, rtn_d;
  logic               sub_q, sub_d;
  logic [NSIG-1:0]    sig_q, sig_d;

  // current line fields
  logic               ln_call, ln_ret, ln_sval, ln_inf;
  logic [TGT_W-1:0]   ln_tgt;
  logic [REP_W-1:0]   ln_rep;
  logic [CW-1:0]      ln_wcond, ln_jcond;
  logic [SSEL_W-1:0]  ln_ssel;
  logic [LINE_AW-1:0] ln_jline;

  logic [AW-1:0] bk_start, bk_last;
  logic          wait_raw, jump_raw, manual;
  logic          wait_ok, jump_ok;
  logic          ag_load, ag_adv, ag_final;

  // fall-through successor of the current line
  logic [LINE_AW-1:0] nx_pc;
  logic               nx_sub;
  logic               nx_end;

  blkseq_linemem #(
    .LINE_AW(LINE_AW), .TGT_W(TGT_W), .REP_W(REP_W), .CW(CW), .SSEL_W(SSEL_W)
  ) u_lines (
    .clk(clk), .we(seq_we), .waddr(seq_waddr),
    .w_call(seq_w_call), .w_ret(seq_w_ret), .w_tgt(seq_w_tgt), .w_rep(seq_w_rep),
    .w_inf(seq_w_inf), .w_wcond(seq_w_wcond), .w_ssel(seq_w_ssel), .w_sval(seq_w_sval),
    .w_jcond(seq_w_jcond), .w_jline(seq_w_jline),
    .raddr(pc_q),
    .r_call(ln_call), .r_ret(ln_ret), .r_tgt(ln_tgt), .r_rep(ln_rep), .r_inf(ln_inf),
    .r_wcond(ln_wcond), .r_ssel(ln_ssel), .r_sval(ln_sval), .r_jcond(ln_jcond),
    .r_jline(ln_jline)
  );

  blkseq_blktab #(.BLK_AW(BLK_AW), .AW(AW)) u_blocks (
    .clk(clk), .we(blk_we), .waddr(blk_waddr),
    .w_start(blk_w_start), .w_last(blk_w_last),
    .raddr(ln_tgt[BLK_AW-1:0]),
    .r_start(bk_start), .r_last(bk_last)
  );

  blkseq_condtab #(.EV_W(EV_W), .CW(CW)) u_conds (
    .clk(clk), .we(cnd_we), .w_idx(cnd_w_idx), .w_pat(cnd_w_pat), .w_val(cnd_w_val),
    .ev(ev_in), .idx_a(ln_wcond), .idx_b(ln_jcond),
    .hit_a(wait_raw), .hit_b(jump_raw)
  );

  blkseq_addrgen #(.AW(AW), .REP_W(REP_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(ag_load), .adv(ag_adv),
    .base_in(bk_start), .span_in(bk_last), .rep_in(ln_rep), .inf_in(ln_inf),
    .addr(vec_addr), .last_vec(ag_final)
  );

  assign manual  = step_mode && step_go;
  assign wait_ok = wait_raw || manual;
  assign jump_ok = jump_raw || manual;

  always_comb begin
    nx_pc  = pc_q + 1'b1;
    nx_sub = sub_q;
    nx_end = 1'b0;
    if (ln_ret && sub_q) begin
      nx_pc  = rtn_q;
      nx_sub = 1'b0;
    end else if (pc_q == '1) begin
      nx_pc  = pc_q;
      nx_end = 1'b1;
    end
  end

  // next-state logic
  always_comb begin
    st_d    = st_q;
    pc_d    = pc_q;
    rtn_d   = rtn_q;
    sub_d   = sub_q;
    sig_d   = sig_q;
    ag_load = 1'b0;
    ag_adv  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (run_en) begin
          pc_d  = '0;
          sub_d = 1'b0;
          sig_d = '0;
          st_d  = ST_LOAD;
        end
      end
      ST_LOAD: begin
        if (ln_call && !sub_q) begin
          rtn_d = pc_q + 1'b1;
          sub_d = 1'b1;
          pc_d  = ln_tgt[LINE_AW-1:0];
        end else if (ln_call) begin
          // second-level call: skipped like an empty line
          pc_d  = nx_pc;
          sub_d = nx_sub;
          st_d  = nx_end ? ST_DONE : ST_LOAD;
        end else begin
          ag_load = 1'b1;
          st_d    = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (wait_ok) begin
          sig_d[ln_ssel] = ln_sval;
          st_d           = ST_PLAY;
        end
      end
      ST_PLAY: begin
        ag_adv = 1'b1;
        if (ag_final) st_d = ST_JUMP;
      end
      ST_JUMP: begin
        if (jump_ok) begin
          pc_d = ln_jline;
          st_d = ST_LOAD;
        end else begin
          pc_d  = nx_pc;
          sub_d = nx_sub;
          st_d  = nx_end ? ST_DONE : ST_LOAD;
        end
      end
      ST_DONE: st_d = ST_DONE;
      default: st_d = ST_IDLE;
    endcase
    if (!run_en) begin
      st_d   = ST_IDLE;
      ag_adv = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      pc_q  <= '0;
      rtn_q <= '0;
      sub_q <= 1'b0;
      sig_q <= '0;
    end else begin
      st_q  <= st_d;
      pc_q  <= pc_d;
      rtn_q <= rtn_d;
      sub_q <= sub_d;
      sig_q <= sig_d;
    end
  end

  assign vec_valid = (st_q == ST_PLAY);
  assign running   = (st_q != ST_IDLE) && (st_q != ST_DONE);
  assign done      = (st_q == ST_DONE);
  assign sig_out   = sig_q;

endmodule

// File: rtl/blkseq_chk.sv
module blkseq_chk #(
  parameter int AW   = 12,
  parameter int NSIG = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            run_en,
  input logic            vec_valid,
  input logic [AW-1:0]   vec_addr,
  input logic [NSIG-1:0] sig_out,
  input logic            running,
  input logic            done
);

  p_valid_in_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> running);

  p_addr_walk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && $past(vec_valid)) |->
      ((vec_addr == $past(vec_addr) + 1'b1) || (vec_addr <= $past(vec_addr))));

  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!running && !vec_valid));

  p_done_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && run_en) |=> done);

  p_stop_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!running && !done));

  p_sig_at_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && !$stable(sig_out)) |-> (vec_valid && !$past(vec_valid)));

endmodule

bind blkseq_engine blkseq_chk #(.AW(AW), .NSIG(NSIG)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .vec_valid(vec_valid),
  .vec_addr(vec_addr), .sig_out(sig_out), .running(running), .done(done)
);

// File: tb/blkseq_engine_bench.sv
`timescale 1ns/1ps
module blkseq_engine_bench;
  localparam int EVW = 8, LAW = 3, BAW = 3, CWD = 2, AWD = 12, RW = 16, NS = 4;
  localparam int TW  = (BAW > LAW) ? BAW : LAW;
  localparam int SW  = $clog2(NS);
  localparam int NEXP = 24;

  // {expected sig_out, expected vec_addr} per output vector of the main program
  localparam logic [15:0] EXP [NEXP] = '{
    {4'b0001, 12'd100}, {4'b0001, 12'd101}, {4'b0001, 12'd102},
    {4'b0001, 12'd100}, {4'b0001, 12'd101}, {4'b0001, 12'd102},
    {4'b1001, 12'd200}, {4'b1001, 12'd201},
    {4'b0001, 12'd100}, {4'b0001, 12'd101}, {4'b0001, 12'd102},
    {4'b0011, 12'd300},
    {4'b0111, 12'd200}, {4'b0111, 12'd201}, {4'b0111, 12'd200},
    {4'b0111, 12'd201}, {4'b0111, 12'd200}, {4'b0111, 12'd201},
    {4'b1111, 12'd200}, {4'b1111, 12'd201},
    {4'b0111, 12'd100}, {4'b0111, 12'd101}, {4'b0111, 12'd102},
    {4'b0110, 12'd300}
  };

  logic clk, rst_n, run_en, step_mode, step_go;
  logic [EVW-1:0] ev_in;
  logic seq_we, seq_w_call, seq_w_ret, seq_w_inf, seq_w_sval;
  logic [LAW-1:0] seq_waddr, seq_w_jline;
  logic [TW-1:0] seq_w_tgt;
  logic [RW-1:0] seq_w_rep;
  logic [CWD-1:0] seq_w_wcond, seq_w_jcond, cnd_w_idx;
  logic [SW-1:0] seq_w_ssel;
  logic blk_we, cnd_we, cnd_w_val;
  logic [BAW-1:0] blk_waddr;
  logic [AWD-1:0] blk_w_start, blk_w_last, vec_addr;
  logic [EVW-1:0] cnd_w_pat;
  logic vec_valid, running, done;
  logic [NS-1:0] sig_out;

  int n_chk = 0;
  int n_bad = 0;

  blkseq_engine #(
    .EV_W(EVW), .LINE_AW(LAW), .BLK_AW(BAW), .CW(CWD), .AW(AWD), .REP_W(RW), .NSIG(NS)
  ) u_blkseq_engine (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .ev_in(ev_in),
    .step_mode(step_mode), .step_go(step_go),
    .seq_we(seq_we), .seq_waddr(seq_waddr), .seq_w_call(seq_w_call), .seq_w_ret(seq_w_ret),
    .seq_w_tgt(seq_w_tgt), .seq_w_rep(seq_w_rep), .seq_w_inf(seq_w_inf),
    .seq_w_wcond(seq_w_wcond), .seq_w_ssel(seq_w_ssel), .seq_w_sval(seq_w_sval),
    .seq_w_jcond(seq_w_jcond), .seq_w_jline(seq_w_jline),
    .blk_we(blk_we), .blk_waddr(blk_waddr), .blk_w_start(blk_w_start), .blk_w_last(blk_w_last),
    .cnd_we(cnd_we), .cnd_w_idx(cnd_w_idx), .cnd_w_pat(cnd_w_pat), .cnd_w_val(cnd_w_val),
    .vec_addr(vec_addr), .vec_valid(vec_valid), .sig_out(sig_out),
    .running(running), .done(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr_line(input int a, input bit call, input bit ret, input int tgt,
                         input int rep, input bit inf, input int wc, input int ss,
                         input bit sv, input int jc, input int jl);
    seq_waddr = LAW'(a); seq_w_call = call; seq_w_ret = ret; seq_w_tgt = TW'(tgt);
    seq_w_rep = RW'(rep); seq_w_inf = inf; seq_w_wcond = CWD'(wc); seq_w_ssel = SW'(ss);
    seq_w_sval = sv; seq_w_jcond = CWD'(jc); seq_w_jline = LAW'(jl);
    seq_we = 1'b1;
    @(negedge clk);
    seq_we = 1'b0;
  endtask

  task automatic wr_blk(input int b, input int st, input int lst);
    blk_waddr = BAW'(b); blk_w_start = AWD'(st); blk_w_last = AWD'(lst);
    blk_we = 1'b1;
    @(negedge clk);
    blk_we = 1'b0;
  endtask

  task automatic wr_cnd(input int idx, input int pat, input bit v);
    cnd_w_idx = CWD'(idx); cnd_w_pat = EVW'(pat); cnd_w_val = v;
    cnd_we = 1'b1;
    @(negedge clk);
    cnd_we = 1'b0;
  endtask

  task automatic stop_run();
    run_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int got;
    int idle;
    int cnt;
    rst_n = 1'b0; run_en = 1'b0; step_mode = 1'b0; step_go = 1'b0; ev_in = '0;
    seq_we = 1'b0; seq_waddr = '0; seq_w_call = 1'b0; seq_w_ret = 1'b0; seq_w_tgt = '0;
    seq_w_rep = '0; seq_w_inf = 1'b0; seq_w_wcond = '0; seq_w_ssel = '0; seq_w_sval = 1'b0;
    seq_w_jcond = '0; seq_w_jline = '0;
    blk_we = 1'b0; blk_waddr = '0; blk_w_start = '0; blk_w_last = '0;
    cnd_we = 1'b0; cnd_w_idx = '0; cnd_w_pat = '0; cnd_w_val = 1'b0;

    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", 32'(vec_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "valid", 32'(vec_valid), 0);
    chk("R1", "running", 32'(running), 0);
    chk("R1", "done", 32'(done), 0);
    chk("R1", "sig_out", 32'(sig_out), 0);

    // blocks: 0 -> 100..102, 1 -> 200..201, 2 -> 300
    wr_blk(0, 100, 2);
    wr_blk(1, 200, 1);
    wr_blk(2, 300, 0);
    // condition index 2: true only for event pattern 8'hA5
    wr_cnd(2, 8'h00, 1'b0);
    wr_cnd(2, 8'hA5, 1'b1);
    //      line call ret tgt rep inf wc ss sv jc jl
    wr_line(0, 0, 0, 0, 1, 0, 0, 0, 1, 1, 0);
    wr_line(1, 1, 0, 5, 0, 0, 0, 0, 0, 1, 0);
    wr_line(2, 0, 0, 2, 0, 0, 2, 1, 1, 0, 4);
    wr_line(3, 0, 0, 1, 0, 0, 0, 0, 0, 1, 0);
    wr_line(4, 0, 0, 1, 2, 0, 0, 2, 1, 1, 0);
    wr_line(5, 0, 0, 1, 0, 0, 0, 3, 1, 1, 0);
    wr_line(6, 0, 1, 0, 0, 0, 0, 3, 0, 1, 0);
    wr_line(7, 0, 0, 2, 0, 0, 0, 0, 0, 1, 0);

    // main program: table walk
    run_en = 1'b1;
    got = 0;
    idle = 0;
    for (int cyc = 0; cyc < 400 && !done; cyc++) begin
      @(negedge clk);
      if (vec_valid) begin
        if (got < NEXP) begin
          chk("R3 R7 R9", $sformatf("addr #%0d", got), 32'(vec_addr), 32'(EXP[got][11:0]));
          chk("R8", $sformatf("sig_out #%0d", got), 32'(sig_out), 32'(EXP[got][15:12]));
        end
        got++;
        idle = 0;
      end else begin
        idle++;
        if (got == 11 && idle == 20) begin
          chk("R5 R6", "stalled valid", 32'(vec_valid), 0);
          chk("R5", "stalled running", 32'(running), 1);
          ev_in = 8'hA5;
        end
      end
    end
    chk("R7 R9", "vector count", 32'(got), NEXP);
    chk("R10", "done", 32'(done), 1);
    repeat (3) @(negedge clk);
    chk("R10", "done held", 32'(done), 1);
    chk("R10", "running after end", 32'(running), 0);
    chk("R10", "valid after end", 32'(vec_valid), 0);
    run_en = 1'b0;
    @(negedge clk);
    chk("R12", "done after stop", 32'(done), 0);
    @(negedge clk);

    // maximum replay count on a 1-vector block, then branch to last line
    wr_line(0, 0, 0, 2, 16'hFFFF, 0, 0, 0, 1, 0, 7);
    run_en = 1'b1;
    cnt = 0;
    for (int cyc = 0; cyc < 70000 && !done; cyc++) begin
      @(negedge clk);
      if (vec_valid) cnt++;
    end
    chk("R3", "65536 replays plus last line", 32'(cnt), 65537);
    stop_run();

    // start timing, signal clear, endless replay, stop
    wr_line(0, 0, 0, 1, 0, 1, 0, 1, 1, 1, 0);
    run_en = 1'b1;
    @(negedge clk);
    chk("R2", "valid 1st cycle", 32'(vec_valid), 0);
    chk("R2", "signals cleared", 32'(sig_out), 0);
    @(negedge clk);
    chk("R2", "valid 2nd cycle", 32'(vec_valid), 0);
    @(negedge clk);
    chk("R2", "valid 3rd cycle", 32'(vec_valid), 1);
    chk("R2", "first addr", 32'(vec_addr), 200);
    cnt = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (vec_valid) cnt++;
    end
    chk("R4", "endless valid cycles", 32'(cnt), 60);
    run_en = 1'b0;
    @(negedge clk);
    chk("R12", "running after stop", 32'(running), 0);
    chk("R12", "valid after stop", 32'(vec_valid), 0);
    @(negedge clk);

    // step mode: never-true start condition and never-true branch
    wr_line(0, 0, 0, 2, 0, 0, 1, 2, 1, 1, 3);
    wr_line(3, 0, 0, 1, 0, 0, 0, 1, 1, 1, 0);
    step_mode = 1'b1;
    run_en = 1'b1;
    repeat (10) @(negedge clk);
    chk("R11", "stall before step", 32'(vec_valid), 0);
    chk("R11", "running before step", 32'(running), 1);
    step_go = 1'b1;
    @(negedge clk);
    step_go = 1'b0;
    chk("R11", "valid after step", 32'(vec_valid), 1);
    chk("R11", "addr after step", 32'(vec_addr), 300);
    @(negedge clk);
    step_go = 1'b1;
    @(negedge clk);
    step_go = 1'b0;
    cnt = 0;
    for (int i = 0; i < 10 && cnt == 0; i++) begin
      @(negedge clk);
      if (vec_valid) begin
        cnt = 1;
        chk("R11", "addr after forced branch", 32'(vec_addr), 200);
      end
    end
    chk("R11", "branch target reached", 32'(cnt), 1);
    stop_run();

    summary();
    $finish;
  end

endmodule